// File: doc/BRIEF.md
# Fast-Infrared Transmit Frame Sequencer

This block sequences one outgoing fast-infrared frame. Software writes a frame length in bytes, which starts a new frame. It then pushes that many payload bytes into a small transmit FIFO, either directly or through a DMA engine. The sequencer hands the bytes one at a time to the modulator over a valid/ready handshake. When CRC generation is on, it then sends four CRC-32 bytes.

The block keeps a writable indication that software or DMA uses to pace its pushes. It also keeps two sticky status flags: underrun, raised when the modulator asks for a byte that has not been supplied, and frame-end, raised when the last byte has gone out. Both flags are set only in DMA mode. An interrupt output combines the two flags, each behind its own mask. Dropping the transmit enable flushes the whole transmitter and closes the modulator clock gate.

Top module: `irfir_tx_frame`

## Requirements
- R1: `writable` is high only while `tx_en` is high, a frame is in its payload phase, the FIFO is not full, and fewer than the programmed number of bytes have been pushed. A push (`wr_valid`) made while `writable` is low is ignored and never reaches `tx_byte`.
- R2: The FIFO holds DEPTH (16) bytes. Payload bytes leave on `tx_byte` in push order. A byte transfers at each clock edge where `tx_valid` and `tx_ready` are both high.
- R3: With `crc_en` high, exactly four bytes follow the payload. They are the complement of a CRC-32 register: reflected polynomial 0xEDB88320 (0x04C11DB7 bit-reversed), preset to all ones, least significant byte first. For the payload "123456789" the bytes are 26 39 F4 CB.
- R4: With `crc_en` low, the frame ends right after the last payload byte. A zero length goes straight to the CRC bytes, or, with CRC off, ends at once.
- R5: `underrun` is set at an edge where the frame is in its payload phase, the FIFO is empty, `tx_ready` is high and `dma_en` is high. It is never set while `dma_en` is low.
- R6: `eof_done` is set at the edge that accepts the frame's final byte (payload or CRC), provided `dma_en` is high. It is never set while `dma_en` is low.
- R7: Both flags stay set until a `clr_underrun` or `clr_eof` pulse clears them. If a set and a clear occur together, the set wins.
- R8: `irq` is high exactly when `underrun` is high and `mask_underrun` is low, or when `eof_done` is high and `mask_eof` is low.
- R9: While `tx_en` is low, the FIFO, the counters, the frame state and both flags are held cleared, and `len_wr` is ignored. After an edge with `tx_en` low, `tx_valid`, `writable`, `mod_clk_en` and `irq` are all low.
- R10: `len_wr` starts a new frame. It flushes the FIFO, restarts the pushed and sent byte counts and the CRC, and clears `eof_done`.
- R11: `mod_clk_en` is high only while `tx_en` is high and a frame is in its payload or CRC phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable; low flushes all transmit state |
| crc_en | input | 1 | Append four CRC bytes to the frame |
| dma_en | input | 1 | DMA mode; the status flags are set only while this is high |
| len_wr | input | 1 | Pulse: load `len_val` and start a frame |
| len_val | input | LEN_W | Frame payload length in bytes |
| wr_valid | input | 1 | Payload byte push strobe |
| wr_data | input | 8 | Payload byte |
| writable | output | 1 | A push would be accepted |
| tx_byte | output | 8 | Byte offered to the modulator |
| tx_valid | output | 1 | `tx_byte` is valid |
| tx_ready | input | 1 | Modulator takes a byte this cycle |
| mod_clk_en | output | 1 | Modulator clock gate enable |
| underrun | output | 1 | Sticky underrun flag |
| eof_done | output | 1 | Sticky frame-end flag |
| clr_underrun | input | 1 | Clear pulse for `underrun` |
| clr_eof | input | 1 | Clear pulse for `eof_done` |
| mask_underrun | input | 1 | Block `underrun` from `irq` |
| mask_eof | input | 1 | Block `eof_done` from `irq` |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted FIFO pointer or count shows within one handshake as a wrong, missing or extra byte on `tx_byte`. The scoreboard compares every transferred byte against the queued expectation, so such an error is caught at once.

A pushed-byte counter that is off by one shows in `writable` at the push that should close the frame. A sent-byte counter error shows as `eof_done` rising early or late, or as the CRC bytes starting at the wrong point. A corrupted CRC register shows only in the last four bytes of a frame, so each CRC frame ends with those four bytes being checked.

// File: rtl/irfir_tx_frame.sv
module irfir_tx_frame #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             crc_en,
  input  logic             dma_en,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             writable,
  output logic [7:0]       tx_byte,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             mod_clk_en,
  output logic             underrun,
  output logic             eof_done,
  input  logic             clr_underrun,
  input  logic             clr_eof,
  input  logic             mask_underrun,
  input  logic             mask_eof,
  output logic             irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_CRC, ST_DONE} st_t;

  st_t              st;
  logic [7:0]       mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    fcnt;
  logic [LEN_W-1:0] len_q, wcnt, scnt;
  logic [31:0]      crc_q;
  logic [1:0]       cidx;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    return r;
  endfunction

  wire full  = (fcnt == CW'(DEPTH));
  wire empty = (fcnt == '0);
  wire in_data = (st == ST_DATA);
  wire in_crc  = (st == ST_CRC);

  assign writable   = tx_en && in_data && !full && (wcnt < len_q);
  assign tx_valid   = tx_en && ((in_data && !empty) || in_crc);
  assign mod_clk_en = tx_en && (in_data || in_crc);

  wire [31:0] crc_out = ~crc_q;
  assign tx_byte = in_crc ? crc_out[8*cidx +: 8] : mem[rp];

  wire push      = wr_valid && writable;
  wire pop       = in_data && !empty && tx_ready && tx_en;
  wire last_data = pop && (scnt == len_q - 1'b1);
  wire crc_last  = in_crc && tx_ready && (cidx == 2'd3);
  wire frame_end = (last_data && !crc_en) || crc_last;
  wire uflow_evt = in_data && empty && tx_ready && dma_en;
  wire zero_end  = (len_val == '0) && !crc_en;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; wp <= '0; rp <= '0; fcnt <= '0;
      len_q <= '0; wcnt <= '0; scnt <= '0;
      crc_q <= '1; cidx <= '0;
    end else if (!tx_en) begin
      st <= ST_IDLE; wp <= '0; rp <= '0; fcnt <= '0;
      len_q <= '0; wcnt <= '0; scnt <= '0;
      crc_q <= '1; cidx <= '0;
    end else if (len_wr) begin
      len_q <= len_val; wcnt <= '0; scnt <= '0;
      wp <= '0; rp <= '0; fcnt <= '0;
      crc_q <= '1; cidx <= '0;
      if (len_val != '0) st <= ST_DATA;
      else               st <= crc_en ? ST_CRC : ST_DONE;
    end else begin
      if (push) begin
        wp   <= ptr_inc(wp);
        wcnt <= wcnt + 1'b1;
      end
      if (pop) begin
        rp    <= ptr_inc(rp);
        scnt  <= scnt + 1'b1;
        crc_q <= crc_step(crc_q, mem[rp]);
      end
      case ({push, pop})
        2'b10:   fcnt <= fcnt + 1'b1;
        2'b01:   fcnt <= fcnt - 1'b1;
        default: fcnt <= fcnt;
      endcase
      if (last_data)
        st <= crc_en ? ST_CRC : ST_DONE;
      if (in_crc && tx_ready) begin
        cidx <= cidx + 1'b1;
        if (cidx == 2'd3) st <= ST_DONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun <= 1'b0;
      eof_done <= 1'b0;
    end else if (!tx_en) begin
      underrun <= 1'b0;
      eof_done <= 1'b0;
    end else begin
      if (uflow_evt && !len_wr)  underrun <= 1'b1;
      else if (clr_underrun)     underrun <= 1'b0;
      if (len_wr)                eof_done <= zero_end && dma_en;
      else if (frame_end && dma_en) eof_done <= 1'b1;
      else if (clr_eof)          eof_done <= 1'b0;
    end
  end

  assign irq = (underrun && !mask_underrun) || (eof_done && !mask_eof);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= CW'(DEPTH));

  // R1
  push_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= len_q);

  // R2
  sent_le_pushed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scnt <= wcnt);

  // R6
  eof_needs_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eof_done) |-> $past(dma_en));

  // R5
  uflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(dma_en && tx_ready && empty));

  // R9
  disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (fcnt == '0) && !underrun && !eof_done && (st == ST_IDLE));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && tx_en && !clr_underrun) |=> underrun);
endmodule

// File: tb/irfir_tx_frame_tb.sv
`timescale 1ns/1ps
module irfir_tx_frame_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, crc_en = 0, dma_en = 0, len_wr = 0, wr_valid = 0, tx_ready = 0;
  logic clr_underrun = 0, clr_eof = 0, mask_underrun = 0, mask_eof = 0;
  logic [15:0] len_val = '0;
  logic [7:0]  wr_data = '0;
  logic writable, tx_valid, mod_clk_en, underrun, eof_done, irq;
  logic [7:0] tx_byte;

  int vectors = 0, fails = 0;
  logic [8:0] expq [$];

  always #4 clk = ~clk;

  irfir_tx_frame dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .crc_en(crc_en), .dma_en(dma_en),
    .len_wr(len_wr), .len_val(len_val), .wr_valid(wr_valid), .wr_data(wr_data),
    .writable(writable), .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .mod_clk_en(mod_clk_en), .underrun(underrun), .eof_done(eof_done),
    .clr_underrun(clr_underrun), .clr_eof(clr_eof), .mask_underrun(mask_underrun),
    .mask_eof(mask_eof), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [31:0] ref_crc(input logic [7:0] d [$]);
    logic [31:0] c, r;
    c = 32'hFFFF_FFFF;
    foreach (d[k]) begin
      c = c ^ {rev8(d[k]), 24'h0};
      for (int b = 0; b < 8; b++)
        c = c[31] ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
    end
    for (int i = 0; i < 32; i++) r[i] = c[31-i];
    return ~r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (expq.size() == 0) chk("R2 unexpected byte", {24'h0, tx_byte}, 32'hFFFF);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        if (e[8]) chk("R3 crc byte", {24'h0, tx_byte}, {24'h0, e[7:0]});
        else      chk("R2 payload byte", {24'h0, tx_byte}, {24'h0, e[7:0]});
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_frame(input logic [15:0] n);
    @(posedge clk); #1 len_wr = 1; len_val = n;
    @(posedge clk); #1 len_wr = 0;
  endtask

  task automatic raw_write(input logic [7:0] d);
    @(posedge clk); #1 wr_valid = 1; wr_data = d;
    @(posedge clk); #1 wr_valid = 0;
  endtask

  task automatic push(input logic [7:0] d);
    int t = 0;
    while (!writable && t < 500) begin @(negedge clk); t++; end
    raw_write(d);
    expq.push_back({1'b0, d});
  endtask

  task automatic expect_crc(input logic [7:0] d [$]);
    logic [31:0] c;
    c = ref_crc(d);
    for (int i = 0; i < 4; i++) expq.push_back({1'b1, c[8*i +: 8]});
  endtask

  task automatic wait_eof();
    int t = 0;
    while (!eof_done && t < 500) begin @(negedge clk); t++; end
  endtask

  task automatic pulse_clr(input bit u, input bit e);
    @(posedge clk); #1 clr_underrun = u; clr_eof = e;
    @(posedge clk); #1 clr_underrun = 0; clr_eof = 0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] pl [$];
    cyc(2);
    chk("R9 reset writable", writable, 0);
    chk("R9 reset tx_valid", tx_valid, 0);
    chk("R9 reset irq", irq, 0);
    chk("R11 reset gate", mod_clk_en, 0);
    rst_n = 1; cyc(1);
    @(posedge clk); #1 tx_en = 1; dma_en = 1; crc_en = 1;
    cyc(2);
    chk("R1 no frame, not writable", writable, 0);

    // R3 known vector and CRC append
    pl = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
    chk("R3 reference crc", ref_crc(pl), 32'hCBF4_3926);
    start_frame(16'd9);
    @(negedge clk);
    chk("R1 writable after length", writable, 1);
    foreach (pl[k]) push(pl[k]);
    expect_crc(pl);
    @(negedge clk);
    chk("R1 writable low after all bytes", writable, 0);
    chk("R11 gate on during frame", mod_clk_en, 1);
    raw_write(8'hEE);
    @(posedge clk); #1 tx_ready = 1;
    wait_eof();
    chk("R6 eof set after crc", eof_done, 1);
    chk("R3 all bytes out", expq.size(), 0);
    chk("R8 irq from eof", irq, 1);
    chk("R11 gate off when done", mod_clk_en, 0);
    @(posedge clk); #1 mask_eof = 1;
    @(negedge clk);
    chk("R8 eof masked", irq, 0);
    cyc(3);
    chk("R7 eof sticky", eof_done, 1);
    pulse_clr(0, 1);
    @(negedge clk);
    chk("R7 eof cleared", eof_done, 0);
    mask_eof = 0;

    // R4 crc off, FIFO full
    crc_en = 0; tx_ready = 0;
    start_frame(16'd20);
    for (int i = 0; i < 16; i++) push(8'(8'hA0 + i));
    @(negedge clk);
    chk("R1 writable low when full", writable, 0);
    raw_write(8'h77);
    @(posedge clk); #1 tx_ready = 1;
    for (int i = 16; i < 20; i++) push(8'(8'hA0 + i));
    wait_eof();
    chk("R4 eof after payload only", eof_done, 1);
    cyc(4);
    chk("R4 no extra bytes", expq.size(), 0);
    chk("R4 idle after end", tx_valid, 0);

    // R10 new frame clears eof; R5 underrun
    start_frame(16'd4);
    @(negedge clk);
    chk("R10 eof cleared by length write", eof_done, 0);
    push(8'h11); push(8'h22);
    cyc(4);
    chk("R5 underrun set", underrun, 1);
    chk("R8 irq from underrun", irq, 1);
    @(posedge clk); #1 mask_underrun = 1;
    @(negedge clk);
    chk("R8 underrun masked", irq, 0);
    push(8'h33); push(8'h44);
    wait_eof();
    chk("R6 eof after late bytes", eof_done, 1);
    chk("R8 irq from eof unmasked", irq, 1);
    pulse_clr(1, 1);
    @(negedge clk);
    chk("R7 underrun cleared", underrun, 0);
    chk("R7 eof cleared again", eof_done, 0);
    chk("R8 irq low after clear", irq, 0);
    mask_underrun = 0;

    // R7 set wins over clear
    start_frame(16'd2);
    @(posedge clk); #1 clr_underrun = 1;
    @(posedge clk); #1 clr_underrun = 0;
    @(negedge clk);
    chk("R7 set beats clear", underrun, 1);
    push(8'h5A); push(8'hA5);
    wait_eof();
    pulse_clr(1, 1);

    // R5 R6 dma off
    dma_en = 0;
    start_frame(16'd3);
    push(8'h01);
    cyc(6);
    chk("R5 no underrun without dma", underrun, 0);
    push(8'h02); push(8'h03);
    cyc(10);
    chk("R6 no eof without dma", eof_done, 0);
    chk("R6 frame drained", expq.size(), 0);
    dma_en = 1;

    // R4 zero length with crc
    crc_en = 1;
    start_frame(16'd0);
    begin
      logic [7:0] none [$];
      expect_crc(none);
    end
    wait_eof();
    chk("R4 zero length crc frame", expq.size(), 0);
    chk("R4 zero length eof", eof_done, 1);

    // R9 disable mid-frame
    tx_ready = 0;
    start_frame(16'd5);
    push(8'hC1); push(8'hC2);
    @(negedge clk);
    chk("R11 gate on with data", mod_clk_en, 1);
    @(posedge clk); #1 tx_en = 0;
    expq.delete();
    @(negedge clk);
    chk("R9 tx_valid off", tx_valid, 0);
    chk("R9 writable off", writable, 0);
    chk("R9 gate off", mod_clk_en, 0);
    chk("R9 flags cleared", {underrun, eof_done}, 0);
    start_frame(16'd4);
    @(posedge clk); #1 tx_en = 1;
    @(negedge clk);
    chk("R9 length ignored while disabled", writable, 0);
    chk("R9 nothing to send", tx_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule